// File: doc/BRIEF.md
# Serial Ethernet Transmit Framer

This block builds the serial bit stream of one 10 Mbps Ethernet frame from bytes held in a transmit FIFO. It starts a frame when the FIFO has data and the block is idle. It first sends a fixed preamble and the start-of-frame delimiter. It then pops payload bytes one at a time and shifts each out least significant bit first. A payload that is too short is topped up with zero bytes. When CRC insertion is enabled, the block closes the frame with the complemented CRC-32. The block sends one bit per clock cycle; an external bit-rate enable is left to the integration.

Two events end a frame early. If the FIFO runs dry in the middle of a frame (underflow), or the abort input is high at a byte boundary, the block closes the frame with the uncomplemented CRC. That is the bitwise inverse of the correct check sequence, so every receiver drops the frame. A collision cuts the stream on the next bit. The block then sends 32 one-bits of jam and raises a one-cycle retry request so that the FIFO can rewind to the start of the frame.

The controller is a state machine with six states:
- `ST_IDLE`: waiting for data.
- `ST_PRE`: preamble and delimiter.
- `ST_DATA`: payload.
- `ST_PAD`: zero fill.
- `ST_FCS`: good or bad check sequence.
- `ST_JAM`: jam.

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→PRE | FIFO valid |
| PRE→DATA | First byte available at the end of the delimiter |
| PRE→FCS (bad) | No byte or abort at the end of the delimiter |
| DATA→DATA | Next byte popped |
| DATA→FCS (bad) | Underflow or abort |
| DATA→PAD | Last byte, frame short |
| DATA→FCS (good) / IDLE | Last byte, length reached; FCS if CRC enabled, IDLE if not |
| PAD→FCS (good) / IDLE | Length reached; FCS if CRC enabled, IDLE if not |
| FCS→IDLE | 32 bits sent |
| PRE/DATA/PAD/FCS→JAM | Collision |
| JAM→IDLE | 32 bits sent, with retry |

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_en`, `tx_bit`, `fifo_pop` and `retry_req` are all 0.
- R2: A frame starts on the clock edge at which the block is idle and `fifo_valid` is 1. From the next cycle on, the block sends seven bytes of 0x55 and then 0xD5, each least significant bit first, one bit per cycle.
- R3: Payload bytes follow the delimiter, least significant bit first. `fifo_pop` is high for one cycle during the last bit of the previous byte (or of the delimiter), and `fifo_data` and `fifo_last` are taken at that edge. Each byte is popped exactly once.
- R4: When the byte flagged `fifo_last` ends before 60 payload bytes have been sent, zero bytes follow until the payload plus padding is 60 bytes long.
- R5: With `crc_en` high at frame start, the payload and padding are followed by 32 bits: the one's complement of the CRC-32 computed over them, bit 0 first. The CRC uses the reflected polynomial 0xEDB88320 with preset 0xFFFFFFFF, so the CRC of the ASCII string "123456789" is 0xCBF43926.
- R6: With `crc_en` low at frame start, the frame ends immediately after the last payload or pad bit, with no check sequence.
- R7: If a further byte is needed (the current byte is not flagged last) and `fifo_valid` is 0 at the byte boundary, the frame ends with the uncomplemented CRC of the bytes sent so far. No padding is added, whatever `crc_en` is.
- R8: If `abort_req` is 1 at a payload byte boundary, the frame ends as in R7. `abort_req` has no effect while the block is idle.
- R9: If `collision` is 1 at a clock edge during the preamble, payload, pad or check sequence, exactly 32 one-bits follow from the next cycle, and then the frame ends. `collision` has no effect while idle.
- R10: `retry_req` is 1 exactly during the last jam bit.
- R11: `tx_en` is 1 from the first preamble bit to the last bit of the frame, with no gap, and is 0 for at least one cycle between frames.
- R12: A payload of 60 or more bytes is sent without padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_last | input | 1 | The head byte ends the frame |
| fifo_pop | output | 1 | Head byte taken at this edge |
| crc_en | input | 1 | Append the check sequence; sampled at frame start |
| abort_req | input | 1 | Close the frame with a bad CRC at the next byte boundary |
| collision | input | 1 | Collision seen on the medium |
| tx_bit | output | 1 | Serial data out |
| tx_en | output | 1 | Frame in progress |
| retry_req | output | 1 | Last jam bit; the FIFO should rewind |

## Verification
A bit counter that slips makes every later bit land one position off. This is visible at `tx_bit` within eight cycles, and the delimiter gives it away first. A wrong byte count or pad decision changes the cycle in which `tx_en` falls. A corrupt CRC register is seen only in the last 32 bits of the frame, and only as a mismatch against an independently computed CRC. A stuck collision path shows up one cycle after the collision input, as a missing jam bit.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_JAM
    } tx_state_e;

    typedef enum logic [1:0] {
        TK_GOOD,
        TK_BAD,
        TK_JAM
    } tail_kind_e;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32 #(
    parameter int          CRC_W  = 32,
    parameter logic [31:0] POLY_R = 32'hEDB88320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc_next
);
    localparam logic [CRC_W-1:0] PRESET = '1;

    logic [CRC_W-1:0] crc_q;

    // Serial CRC, one bit per cycle, LSB-first (reflected) form.
    always_comb begin
        crc_next = crc_q;
        if (step) begin
            crc_next = {1'b0, crc_q[CRC_W-1:1]}
                     ^ ((crc_q[0] ^ din) ? POLY_R[CRC_W-1:0] : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= PRESET;
        else if (init) crc_q <= PRESET;
        else           crc_q <= crc_next;
    end
endmodule

// File: rtl/eth_tx_tail.sv
module eth_tx_tail #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         out_bit
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= load_val;
        else if (shift) sh_q <= {1'b0, sh_q[W-1:1]};
    end

    assign out_bit = sh_q[0];
endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int MIN_DATA = 60,
    parameter int CNT_W    = 11,
    parameter int TAIL_W   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_valid,
    input  logic [7:0] fifo_data,
    input  logic       fifo_last,
    input  logic       crc_en,
    input  logic       abort_req,
    input  logic       collision,
    output logic       fifo_pop,
    output tx_state_e  state_o,
    output logic       byte_bit,
    output logic       crc_init,
    output logic       crc_step,
    output logic       tail_load,
    output tail_kind_e tail_kind,
    output logic       retry_req
);
    localparam int TC_W = $clog2(TAIL_W);
    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TAIL_W - 1);

    tx_state_e        state, nxt;
    logic [7:0]       sh8;
    logic [2:0]       bit_cnt;
    logic [2:0]       pre_idx;
    logic [CNT_W-1:0] byte_cnt, cnt_inc;
    logic [TC_W-1:0]  t_cnt;
    logic             last_q, crc_on;
    logic             take, boundary, short_frm;
    tx_state_e        fin_state;

    assign boundary  = (bit_cnt == 3'd7);
    assign cnt_inc   = (byte_cnt == '1) ? byte_cnt : byte_cnt + 1'b1;
    assign short_frm = (32'(cnt_inc) < MIN_DATA);
    assign fin_state = crc_on ? ST_FCS : ST_IDLE;

    // Next state, pop and tail-load decisions.
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        tail_load = 1'b0;
        tail_kind = TK_GOOD;
        unique case (state)
            ST_IDLE: begin
                if (fifo_valid) nxt = ST_PRE;
            end
            ST_PRE: begin
                if (collision) begin
                    nxt = ST_JAM; tail_load = 1'b1; tail_kind = TK_JAM;
                end else if (boundary && pre_idx == 3'd7) begin
                    if (fifo_valid && !abort_req) begin
                        take = 1'b1; nxt = ST_DATA;
                    end else begin
                        nxt = ST_FCS; tail_load = 1'b1; tail_kind = TK_BAD;
                    end
                end
            end
            ST_DATA: begin
                if (collision) begin
                    nxt = ST_JAM; tail_load = 1'b1; tail_kind = TK_JAM;
                end else if (boundary) begin
                    if (abort_req || (!last_q && !fifo_valid)) begin
                        nxt = ST_FCS; tail_load = 1'b1; tail_kind = TK_BAD;
                    end else if (!last_q) begin
                        take = 1'b1;
                    end else if (short_frm) begin
                        nxt = ST_PAD;
                    end else begin
                        nxt = fin_state; tail_load = crc_on;
                    end
                end
            end
            ST_PAD: begin
                if (collision) begin
                    nxt = ST_JAM; tail_load = 1'b1; tail_kind = TK_JAM;
                end else if (boundary && !short_frm) begin
                    nxt = fin_state; tail_load = crc_on;
                end
            end
            ST_FCS: begin
                if (collision) begin
                    nxt = ST_JAM; tail_load = 1'b1; tail_kind = TK_JAM;
                end else if (t_cnt == TC_LAST) begin
                    nxt = ST_IDLE;
                end
            end
            ST_JAM: begin
                if (t_cnt == TC_LAST) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and datapath counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh8      <= PRE_BYTE;
            bit_cnt  <= '0;
            pre_idx  <= '0;
            byte_cnt <= '0;
            t_cnt    <= '0;
            last_q   <= 1'b0;
            crc_on   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                sh8      <= PRE_BYTE;
                bit_cnt  <= '0;
                pre_idx  <= '0;
                byte_cnt <= '0;
                crc_on   <= crc_en;
            end else begin
                bit_cnt <= bit_cnt + 3'd1;
                if (take) begin
                    sh8    <= fifo_data;
                    last_q <= fifo_last;
                end else if (state == ST_PRE && boundary) begin
                    pre_idx <= pre_idx + 3'd1;
                    sh8     <= (pre_idx == 3'd6) ? SFD_BYTE : PRE_BYTE;
                end else begin
                    sh8 <= {1'b0, sh8[7:1]};
                end
                if ((state == ST_DATA || state == ST_PAD) && boundary)
                    byte_cnt <= cnt_inc;
            end
            if (tail_load)                              t_cnt <= '0;
            else if (state == ST_FCS || state == ST_JAM) t_cnt <= t_cnt + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        fifo_pop  = take;
        state_o   = state;
        byte_bit  = sh8[0];
        crc_init  = (state == ST_IDLE);
        crc_step  = (state == ST_DATA || state == ST_PAD);
        retry_req = (state == ST_JAM) && (t_cnt == TC_LAST);
    end

    // R3: a byte is only taken when the FIFO offers one
    a_r3_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid);
    // R1: no pop outside a frame
    a_r1_no_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (state != ST_IDLE));
    // R4: padding is all zeros
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> !byte_bit);
    // R9: a collision during an active frame starts the jam next cycle
    a_r9_collision_jams: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && state inside {ST_PRE, ST_DATA, ST_PAD, ST_FCS})
        |=> (state == ST_JAM && t_cnt == '0));
    // R10: retry request ends the frame
    a_r10_retry_ends: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> (state == ST_IDLE));
    // R7: underflow mid-frame goes to the check sequence
    a_r7_underflow_fcs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && boundary && !last_q && !fifo_valid && !collision)
        |=> (state == ST_FCS));
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int MIN_DATA = 60,
    parameter int CNT_W    = 11,
    parameter int CRC_W    = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_valid,
    input  logic [7:0] fifo_data,
    input  logic       fifo_last,
    output logic       fifo_pop,
    input  logic       crc_en,
    input  logic       abort_req,
    input  logic       collision,
    output logic       tx_bit,
    output logic       tx_en,
    output logic       retry_req
);
    tx_state_e        state;
    tail_kind_e       tail_kind;
    logic             byte_bit, crc_init, crc_step, tail_load, tail_bit;
    logic [CRC_W-1:0] crc_next, tail_val;

    eth_tx_ctrl #(.MIN_DATA(MIN_DATA), .CNT_W(CNT_W), .TAIL_W(CRC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .crc_en(crc_en), .abort_req(abort_req), .collision(collision),
        .fifo_pop(fifo_pop), .state_o(state), .byte_bit(byte_bit),
        .crc_init(crc_init), .crc_step(crc_step),
        .tail_load(tail_load), .tail_kind(tail_kind), .retry_req(retry_req)
    );

    eth_tx_crc32 #(.CRC_W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .step(crc_step),
        .din(byte_bit), .crc_next(crc_next)
    );

    always_comb begin
        unique case (tail_kind)
            TK_GOOD: tail_val = ~crc_next;
            TK_BAD:  tail_val = crc_next;
            TK_JAM:  tail_val = '1;
            default: tail_val = '1;
        endcase
    end

    eth_tx_tail #(.W(CRC_W)) u_tail (
        .clk(clk), .rst_n(rst_n), .load(tail_load), .load_val(tail_val),
        .shift(state == ST_FCS || state == ST_JAM), .out_bit(tail_bit)
    );

    always_comb begin
        tx_en = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:               tx_bit = 1'b0;
            ST_FCS, ST_JAM:        tx_bit = tail_bit;
            ST_PRE, ST_DATA, ST_PAD: tx_bit = byte_bit;
            default:               tx_bit = 1'b0;
        endcase
    end

    // R1: line is quiet outside a frame
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!tx_bit && !retry_req));
    // R11: a frame always opens with a preamble one-bit
    a_r11_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> tx_bit);
endmodule

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
module eth_tx_framer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_valid = 1'b0, fifo_last = 1'b0, crc_en = 1'b0;
    logic abort_req = 1'b0, collision = 1'b0;
    logic [7:0] fifo_data = 8'h00;
    logic fifo_pop, tx_bit, tx_en, retry_req;

    int checks = 0, errors = 0;
    logic [7:0] fq[$];
    bit pop_pend = 0, flush = 0, no_last = 0;
    int pops = 0, abort_at = -1;

    always #2 clk = ~clk;

    eth_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_last(fifo_last), .fifo_pop(fifo_pop), .crc_en(crc_en),
        .abort_req(abort_req), .collision(collision), .tx_bit(tx_bit),
        .tx_en(tx_en), .retry_req(retry_req)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[i][k]) c = (c >> 1) ^ 32'hEDB88320;
                else                c = c >> 1;
            end
        end
        return c;
    endfunction

    // One bit period: FIFO model and input drive at the falling edge,
    // outputs sampled 1 ns later.
    task automatic cycle();
        @(negedge clk);
        collision = 1'b0;
        if (flush) begin fq.delete(); flush = 0; end
        if (pop_pend) begin
            if (fq.size() > 0) void'(fq.pop_front());
            pops++;
        end
        if (abort_at >= 0 && pops == abort_at) abort_req = 1'b1;
        fifo_valid = (fq.size() > 0);
        fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
        fifo_last  = (fq.size() == 1) && !no_last;
        #1;
        pop_pend = fifo_pop;
    endtask

    // mode 0 normal, 1 underflow after arg bytes, 2 abort after arg bytes,
    // 3 collision at stream bit arg
    task automatic run_frame(input int n, input bit crc, input int mode, input int arg);
        logic [7:0] data[$];
        logic [7:0] body[$];
        bit exp_b[$];
        string exp_t[$];
        logic [31:0] c;
        int last, nbody;
        bit started;
        for (int i = 0; i < n; i++) data.push_back(8'((i * 29 + n * 7 + 3) & 255));
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 8; k++) begin
                exp_b.push_back(p == 7 ? 1'((8'hD5 >> k) & 1) : 1'((8'h55 >> k) & 1));
                exp_t.push_back("R2");
            end
        if (mode == 1 || mode == 2) begin
            for (int i = 0; i < arg; i++) body.push_back(data[i]);
            foreach (body[i]) for (int k = 0; k < 8; k++) begin
                exp_b.push_back(body[i][k]); exp_t.push_back("R3");
            end
            c = ref_crc(body);
            for (int k = 0; k < 32; k++) begin
                exp_b.push_back(c[k]); exp_t.push_back(mode == 1 ? "R7" : "R8");
            end
        end else begin
            foreach (data[i]) body.push_back(data[i]);
            nbody = body.size();
            while (body.size() < 60) body.push_back(8'h00);
            foreach (body[i]) for (int k = 0; k < 8; k++) begin
                exp_b.push_back(body[i][k]);
                exp_t.push_back(i < nbody ? "R3" : "R4");
            end
            if (crc) begin
                c = ~ref_crc(body);
                for (int k = 0; k < 32; k++) begin
                    exp_b.push_back(c[k]); exp_t.push_back("R5");
                end
            end
            if (mode == 3) begin
                while (exp_b.size() > arg + 1) begin
                    void'(exp_b.pop_back()); void'(exp_t.pop_back());
                end
                for (int k = 0; k < 32; k++) begin
                    exp_b.push_back(1'b1); exp_t.push_back("R9");
                end
            end
        end
        last = exp_b.size() - 1;
        crc_en = crc;
        pops = 0;
        no_last = (mode == 1);
        abort_at = (mode == 2) ? arg : -1;
        if (mode == 1) for (int i = 0; i < arg; i++) fq.push_back(data[i]);
        else           foreach (data[i]) fq.push_back(data[i]);
        started = 0;
        for (int w = 0; w < 10 && !started; w++) begin
            cycle();
            started = tx_en;
        end
        chk(started, "R2", "frame start tx_en", tx_en, 1);
        for (int i = 0; i <= last; i++) begin
            if (i > 0) cycle();
            chk(tx_en == 1'b1, "R11", $sformatf("tx_en bit %0d", i), tx_en, 1);
            chk(tx_bit == exp_b[i], exp_t[i], $sformatf("tx_bit %0d", i), tx_bit, exp_b[i]);
            chk(retry_req == (mode == 3 && i == last), "R10",
                $sformatf("retry bit %0d", i), retry_req, (mode == 3 && i == last));
            if (mode == 3 && i == arg) collision = 1'b1;
        end
        abort_at = -1;
        abort_req = 1'b0;
        no_last = 0;
        flush = 1;
        cycle();
        chk(tx_en == 1'b0, "R11", "gap after frame", tx_en, 0);
        chk(tx_bit == 1'b0, "R1", "tx_bit idle after frame", tx_bit, 0);
        if (mode == 0) chk(pops == n, "R3", "pop count", pops, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s[$];
        s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        chk((~ref_crc(s)) == 32'hCBF43926, "R5", "reference crc",
            ~ref_crc(s), 32'hCBF43926);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cycle();
            chk(!tx_en && !tx_bit && !fifo_pop && !retry_req, "R1", "reset quiet",
                {tx_en, tx_bit, fifo_pop, retry_req}, 0);
        end
        // R8 / R9: abort and collision ignored while idle
        abort_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cycle();
            collision = 1'b1;
            chk(!tx_en && !tx_bit, "R8", "abort idle ignored", tx_en, 0);
        end
        cycle();
        chk(!tx_en && !retry_req, "R9", "collision idle ignored", tx_en, 0);
        abort_req = 1'b0;
        run_frame(10, 1'b1, 0, 0);   // R4 R5 short, padded
        run_frame(70, 1'b1, 0, 0);   // R12 long
        run_frame(60, 1'b1, 0, 0);   // R12 exact minimum
        run_frame(59, 1'b1, 0, 0);   // R4 one pad byte
        run_frame(10, 1'b0, 0, 0);   // R6 no check sequence
        run_frame(65, 1'b0, 0, 0);   // R6 R12
        run_frame(12, 1'b1, 1, 5);   // R7 underflow
        run_frame(12, 1'b0, 1, 3);   // R7 ignores crc_en
        run_frame(40, 1'b1, 2, 20);  // R8 abort
        run_frame(30, 1'b1, 3, 100); // R9 R10 collision in payload
        run_frame(30, 1'b1, 3, 10);  // R9 collision in preamble
        run_frame(61, 1'b1, 0, 0);   // R11 back-to-back
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule